// File: doc/BRIEF.md
# Superpage Direct Address Mapper

This block turns a 48-bit virtual address into a 44-bit physical address without a TLB lookup. The address must fall inside one of three fixed superpage windows, that window's enable bit must be set, and the access must come from kernel mode. Each window has its own size. Each also fills the physical bits above the copied range in its own way: the largest window copies them straight from the virtual address, the middle one replicates its top mapped bit, and the smallest one forces them to zero.

The requester raises a strobe with the address, a three-bit window-enable field and a kernel-mode flag. One cycle later the block shows a translation-hit flag, an access-violation flag and the physical address. These stay held until the next strobe. If neither flag is set, no enabled window matched, and the address falls through to the normal TLB path. If a window matches while the access is not in kernel mode, the block reports a violation instead of a translation.

Top module: `spm_superpage_map`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, hit, violation and the physical address are all zero.
- R2: Window A is enabled by enable bit 2 and selected when VA[47:46] = 2'b10. On a kernel access the physical address equals VA[43:0], so VA[45:44] have no effect on the result.
- R3: Window B is enabled by enable bit 1 and selected when VA[47:41] = 7'h7E. On a kernel access PA[40:0] = VA[40:0] and each of PA[43:41] equals VA[40].
- R4: Window C is enabled by enable bit 0 and selected when VA[47:30] = 18'h3FFFE. On a kernel access PA[29:0] = VA[29:0] and PA[43:30] are zero.
- R5: If an enabled window matches while the kernel flag is low, violation is 1, hit is 0 and the physical address is zero.
- R6: If no enabled window matches, which includes every request with the enable field at zero, hit and violation are both 0 and the physical address is zero.
- R7: The result of a request appears on the outputs on the clock edge after the strobe cycle. The outputs then hold unchanged, whatever the address, enable and kernel inputs do, until the next strobe.
- R8: The three window tags never match the same address. If more than one window were to match, bit 2 would win over bit 1 and bit 1 over bit 0. Hit and violation are never both 1.
- R9: On every hit, PA[12:0] equals VA[12:0] of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; inputs are sampled in this cycle |
| req_va | input | 48 | Virtual address |
| sp_enable | input | 3 | Window enables: bit 2 for A, bit 1 for B, bit 0 for C |
| kernel_mode | input | 1 | 1 when the access is made in kernel mode |
| rsp_hit | output | 1 | Direct translation is valid |
| rsp_violation | output | 1 | Window matched outside kernel mode |
| rsp_pa | output | 44 | Physical address; zero unless rsp_hit is 1 |

## Verification
The bench builds the block with its default widths: a 48-bit virtual address, a 44-bit physical address and a 13-bit page offset. At these widths the three tag comparators work on their real prefix lengths, so the one-bit difference between window B and window C at VA[41] is exercised directly. The sign fill of window B is driven with VA[40] both low and high. Idle cycles between requests change every input, which exposes any output that is not properly held.

// File: rtl/spm_pkg.sv
package spm_pkg;

  parameter int VA_W   = 48;
  parameter int PA_W   = 44;
  parameter int OFS_W  = 13;
  parameter int NREG   = 3;

  typedef enum logic [1:0] {
    FILL_VA   = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_ZERO = 2'd2
  } spm_fill_e;

  function automatic int reg_tag_lo(input int idx);
    case (idx)
      2:       return 46;
      1:       return 41;
      default: return 30;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] reg_tag_val(input int idx);
    case (idx)
      2:       return VA_W'(48'h2);
      1:       return VA_W'(48'h7E);
      default: return VA_W'(48'h3FFFE);
    endcase
  endfunction

  function automatic int reg_keep_hi(input int idx);
    case (idx)
      2:       return PA_W - 1;
      1:       return 40;
      default: return 29;
    endcase
  endfunction

  function automatic spm_fill_e reg_fill(input int idx);
    case (idx)
      2:       return FILL_VA;
      1:       return FILL_SIGN;
      default: return FILL_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/spm_region_decode.sv
module spm_region_decode
  import spm_pkg::*;
#(
  parameter int               VA_BITS = 48,
  parameter int               PA_BITS = 44,
  parameter int               TAG_LO  = 46,
  parameter logic [VA_BITS-1:0] TAG_VAL = '0,
  parameter int               KEEP_HI = 43,
  parameter spm_fill_e        FILL    = FILL_VA
) (
  input  logic [VA_BITS-1:0] va,
  input  logic               en,
  output logic               tag_hit,
  output logic               win_hit,
  output logic [PA_BITS-1:0] pa
);

  localparam int TAG_W = VA_BITS - TAG_LO;

  function automatic logic [PA_BITS-1:0] build_pa(input logic [VA_BITS-1:0] v);
    logic [PA_BITS-1:0] r;
    for (int b = 0; b < PA_BITS; b++) begin
      if (b <= KEEP_HI)            r[b] = v[b];
      else if (FILL == FILL_SIGN)  r[b] = v[KEEP_HI];
      else if (FILL == FILL_ZERO)  r[b] = 1'b0;
      else                         r[b] = v[b];
    end
    return r;
  endfunction

  assign tag_hit = (va[VA_BITS-1:TAG_LO] == TAG_VAL[TAG_W-1:0]);
  assign win_hit = tag_hit & en;
  assign pa      = build_pa(va);

endmodule

// File: rtl/spm_prio_pick.sv
module spm_prio_pick #(
  parameter int N       = 3,
  parameter int PA_BITS = 44
) (
  input  logic [N-1:0]              hit,
  input  logic [N-1:0][PA_BITS-1:0] pa_in,
  output logic                      any,
  output logic [N-1:0]              grant,
  output logic [PA_BITS-1:0]        pa_out
);

  always_comb begin
    grant  = '0;
    pa_out = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        grant  = '0;
        grant[i] = 1'b1;
        pa_out = pa_in[i];
      end
    end
  end

  assign any = |hit;

endmodule

// File: rtl/spm_resp_reg.sv
module spm_resp_reg #(
  parameter int PA_BITS = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               xlate_ok,
  input  logic               xlate_fault,
  input  logic [PA_BITS-1:0] pa_sel,
  output logic               hit_q,
  output logic               viol_q,
  output logic [PA_BITS-1:0] pa_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      viol_q <= 1'b0;
      pa_q   <= '0;
    end else if (load) begin
      hit_q  <= xlate_ok;
      viol_q <= xlate_fault;
      pa_q   <= xlate_ok ? pa_sel : '0;
    end
  end

endmodule

// File: rtl/spm_superpage_map.sv
module spm_superpage_map
  import spm_pkg::*;
#(
  parameter int VA_BITS = spm_pkg::VA_W,
  parameter int PA_BITS = spm_pkg::PA_W,
  parameter int N_WIN   = spm_pkg::NREG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_BITS-1:0] req_va,
  input  logic [N_WIN-1:0]   sp_enable,
  input  logic               kernel_mode,
  output logic               rsp_hit,
  output logic               rsp_violation,
  output logic [PA_BITS-1:0] rsp_pa
);

  logic [N_WIN-1:0]              region_tag_hit;
  logic [N_WIN-1:0]              region_hit;
  logic [N_WIN-1:0][PA_BITS-1:0] region_pa;
  logic [N_WIN-1:0]              grant;
  logic                          any_hit;
  logic [PA_BITS-1:0]            sel_pa;
  logic                          xlate_ok;
  logic                          xlate_fault;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    spm_region_decode #(
      .VA_BITS (VA_BITS),
      .PA_BITS (PA_BITS),
      .TAG_LO  (reg_tag_lo(g)),
      .TAG_VAL (VA_BITS'(reg_tag_val(g))),
      .KEEP_HI (reg_keep_hi(g)),
      .FILL    (reg_fill(g))
    ) u_dec (
      .va      (req_va),
      .en      (sp_enable[g]),
      .tag_hit (region_tag_hit[g]),
      .win_hit (region_hit[g]),
      .pa      (region_pa[g])
    );
  end

  spm_prio_pick #(
    .N       (N_WIN),
    .PA_BITS (PA_BITS)
  ) u_pick (
    .hit    (region_hit),
    .pa_in  (region_pa),
    .any    (any_hit),
    .grant  (grant),
    .pa_out (sel_pa)
  );

  assign xlate_ok    = any_hit & kernel_mode;
  assign xlate_fault = any_hit & ~kernel_mode;

  spm_resp_reg #(
    .PA_BITS (PA_BITS)
  ) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (req_valid),
    .xlate_ok    (xlate_ok),
    .xlate_fault (xlate_fault),
    .pa_sel      (sel_pa),
    .hit_q       (rsp_hit),
    .viol_q      (rsp_violation),
    .pa_q        (rsp_pa)
  );

endmodule

// File: rtl/spm_superpage_map_chk.sv
module spm_superpage_map_chk #(
  parameter int VA_BITS = 48,
  parameter int PA_BITS = 44,
  parameter int N_WIN   = 3,
  parameter int OFS     = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_BITS-1:0] req_va,
  input logic               kernel_mode,
  input logic [N_WIN-1:0]   region_tag_hit,
  input logic [N_WIN-1:0]   region_hit,
  input logic [N_WIN-1:0]   grant,
  input logic               rsp_hit,
  input logic               rsp_violation,
  input logic [PA_BITS-1:0] rsp_pa
);

  assert_tags_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_tag_hit));

  assert_grant_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|grant) == (|region_hit)));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_violation));

  assert_kernel_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (|region_hit) && kernel_mode |=> rsp_hit && !rsp_violation);

  assert_user_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (|region_hit) && !kernel_mode |=> rsp_violation && !rsp_hit && (rsp_pa == '0));

  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(|region_hit) |=> !rsp_hit && !rsp_violation && (rsp_pa == '0));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_hit) && $stable(rsp_violation) && $stable(rsp_pa));

  assert_offset_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (|region_hit) && kernel_mode |=> rsp_pa[OFS-1:0] == $past(req_va[OFS-1:0]));

endmodule

bind spm_superpage_map spm_superpage_map_chk #(
  .VA_BITS (VA_BITS),
  .PA_BITS (PA_BITS),
  .N_WIN   (N_WIN),
  .OFS     (spm_pkg::OFS_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_va         (req_va),
  .kernel_mode    (kernel_mode),
  .region_tag_hit (region_tag_hit),
  .region_hit     (region_hit),
  .grant          (grant),
  .rsp_hit        (rsp_hit),
  .rsp_violation  (rsp_violation),
  .rsp_pa         (rsp_pa)
);

// File: tb/spm_superpage_map_tb.sv
module spm_superpage_map_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_va = '0;
  logic [2:0]  sp_enable = '0;
  logic        kernel_mode = 1'b0;
  logic        rsp_hit;
  logic        rsp_violation;
  logic [43:0] rsp_pa;

  always #10 clk = ~clk;

  spm_superpage_map u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_va        (req_va),
    .sp_enable     (sp_enable),
    .kernel_mode   (kernel_mode),
    .rsp_hit       (rsp_hit),
    .rsp_violation (rsp_violation),
    .rsp_pa        (rsp_pa)
  );

  typedef struct {
    logic        hit;
    logic        viol;
    logic [43:0] pa;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   checks = 0;
  int   fails = 0;
  logic due = 1'b0;
  logic done = 1'b0;

  function automatic bit in_a(input logic [47:0] v); return v[47] & ~v[46]; endfunction
  function automatic bit in_b(input logic [47:0] v); return v[47:41] == 7'b1111110; endfunction
  function automatic bit in_c(input logic [47:0] v); return (&v[47:31]) & ~v[30]; endfunction

  function automatic exp_t model(input logic [47:0] v, input logic [2:0] en,
                                 input logic k, input string tag);
    exp_t e;
    logic m;
    logic [43:0] p;
    m = 1'b1;
    if (en[2] && in_a(v))      p = v[43:0];
    else if (en[1] && in_b(v)) p = {v[40], v[40], v[40], v[40:0]};
    else if (en[0] && in_c(v)) p = {14'd0, v[29:0]};
    else begin m = 1'b0; p = '0; end
    e.hit  = m & k;
    e.viol = m & ~k;
    e.pa   = (m & k) ? p : 44'd0;
    e.req  = tag;
    return e;
  endfunction

  task automatic cmp(input exp_t e, input string note);
    checks++;
    if (rsp_hit !== e.hit || rsp_violation !== e.viol || rsp_pa !== e.pa) begin
      fails++;
      $display("FAIL %s %s: actual hit=%b viol=%b pa=%h expected hit=%b viol=%b pa=%h",
               e.req, note, rsp_hit, rsp_violation, rsp_pa, e.hit, e.viol, e.pa);
    end
  endtask

  always @(posedge clk) due <= req_valid & rst_n;

  // monitor: compare popped items on result cycles, held value on idle cycles
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (due) begin
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R7: actual result with no pending request, expected none");
        end else begin
          last = q.pop_front();
          cmp(last, "result");
        end
      end else begin
        exp_t h;
        h = last;
        h.req = "R7";
        cmp(h, "hold");
      end
    end
  end

  task automatic send(input logic [47:0] v, input logic [2:0] en,
                      input logic k, input string tag);
    @(negedge clk);
    req_va = v; sp_enable = en; kernel_mode = k; req_valid = 1'b1;
    q.push_back(model(v, en, k, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      sp_enable = 3'($urandom);
      kernel_mode = 1'($urandom);
    end
  endtask

  task automatic chk_bit(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] va_a0, va_a1, va_b0, va_b1, va_c0;
    last.hit = 1'b0; last.viol = 1'b0; last.pa = '0; last.req = "R1";
    repeat (4) @(negedge clk);
    // R1: outputs zero under reset
    chk_bit(rsp_hit | rsp_violation | (|rsp_pa), 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit(rsp_hit | rsp_violation | (|rsp_pa), 1'b0, "R1 after reset");
    idle(3);

    va_a0 = {2'b10, 2'b00, 31'h1234_5678, 13'h0ABC};
    va_a1 = {2'b10, 2'b11, 31'h1234_5678, 13'h0ABC};
    va_b0 = {7'h7E, 41'h0_1357_9BDF_1};
    va_b1 = {7'h7E, 41'h1_2468_ACE0_3};
    va_c0 = {18'h3FFFE, 30'h2BAD_CAFE};

    // R8: tag windows are disjoint (bench-side independent decode)
    chk_bit(in_a(va_a0) + in_b(va_a0) + in_c(va_a0) == 1, 1'b1, "R8 tags A");
    chk_bit(in_a(va_b0) + in_b(va_b0) + in_c(va_b0) == 1, 1'b1, "R8 tags B");
    chk_bit(in_a(va_c0) + in_b(va_c0) + in_c(va_c0) == 1, 1'b1, "R8 tags C");

    send(va_a0, 3'b100, 1'b1, "R2");
    send(va_a1, 3'b100, 1'b1, "R2");
    idle(2);
    send(va_b0, 3'b010, 1'b1, "R3");
    send(va_b1, 3'b010, 1'b1, "R3");
    send(va_c0, 3'b001, 1'b1, "R4");
    idle(1);
    send(va_a0, 3'b111, 1'b0, "R5");
    send(va_b1, 3'b111, 1'b0, "R5");
    send(va_c0, 3'b001, 1'b0, "R5");
    send(va_a0, 3'b000, 1'b1, "R6");
    send(va_c0, 3'b110, 1'b1, "R6");
    send(48'h0000_1234_5678, 3'b111, 1'b1, "R6");
    send({7'h7F, 41'h0}, 3'b010, 1'b1, "R6");
    idle(2);
    send(va_a1, 3'b111, 1'b1, "R8");
    send(va_b0, 3'b111, 1'b1, "R8");
    send(va_c0, 3'b111, 1'b1, "R8");
    send({2'b10, 33'h0, 13'h1FFF}, 3'b100, 1'b1, "R9");
    send({7'h7E, 28'h0, 13'h1555}, 3'b010, 1'b1, "R9");

    for (int i = 0; i < 300; i++) begin
      logic [47:0] v;
      v = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      case ($urandom % 4)
        0: v[47:46] = 2'b10;
        1: v[47:41] = 7'h7E;
        2: v[47:30] = 18'h3FFFE;
        default: ;
      endcase
      send(v, 3'($urandom), 1'($urandom), "R9");
      if (($urandom % 3) == 0) idle(1);
    end
    idle(3);
    chk_bit(q.size() == 0, 1'b1, "R7 queue drained");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule